// File: doc/BRIEF.md
# Arithmetic Shift-Right Immediate Execute Slice

This block is the execute stage for one instruction of a 32-bit RISC core: an arithmetic right shift of a register by a constant amount. Each issued instruction word arrives with a tag that names its layout. There is one short 16-bit layout and there are two 32-bit layouts. The block extracts the destination, source and shift-amount fields for that layout. It drives the source index out to the core's 16-entry register file and takes the operand back on the same cycle. It then shifts the operand right, filling from the top with copies of the sign bit.

On the next rising clock edge the block registers a write request. The request goes either to the register file or, when the destination is the program counter, to a separate PC-write port. The block also registers an updated N/Z/C/V flag word. A condition-check result decided upstream arrives as a single pass input. A failed check turns the instruction into a no-op. Register numbers that are illegal in the wide 16-bit-register layout, and the unused layout tag, raise an undefined-instruction pulse instead of writing anything.

Top module: `asr_exec_unit`

## Requirements
- R1: `src_idx` follows the source field of the current instruction within the same cycle. The field is bits [5:3] zero-extended for the short form (`form`=0), and bits [3:0] for the wide form (`form`=1) and the classic form (`form`=2).
- R2: In the short form the destination is bits [2:0] and the shift field is bits [10:6]. Flags are updated only when `in_it_block` is 0.
- R3: In the wide form the destination is bits [11:8]. The shift field is {bits [14:12], bits [7:6]}, with bits [14:12] as the upper three bits. Bit 20 enables the flag update.
- R4: In the wide form, a destination or source of 13 or 15 raises `undef` and produces no register, PC or flag write.
- R5: In the classic form the destination is bits [15:12], the shift field is bits [11:7], and bit 20 enables the flag update.
- R6: The result is the operand shifted right by the shift field value (1 to 31), with bit 31 copied in from the top. A field of 0 means a shift of 32, which gives all bits equal to bit 31. The carry is the last bit shifted out, and equals bit 31 for a shift of 32.
- R7: On a flag update, `flags_out` = {N, Z, C, V} with N = result bit 31, Z = (result == 0), C = the carry, and V = `flags_in`[0]. Without a flag update, `flags_out` equals `flags_in`.
- R8: A classic-form destination of 15 raises `pc_we` with the result on `pc_wdata`. It raises neither `rf_we` nor `flags_we`, even when bit 20 is set.
- R9: When `cond_pass` is 0 or `issue` is 0, nothing is written, `undef` stays 0, and `flags_out` equals `flags_in`.
- R10: All outputs except `src_idx` are registered on the rising edge of `clk`. A synchronous, active-high `rst` clears every enable, `undef` and `flags_out`.
- R11: A `form` value of 3 is undefined. When issued with a passing condition it raises `undef` and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Instruction valid this cycle |
| cond_pass | input | 1 | Upstream condition check passed |
| in_it_block | input | 1 | Core is inside a conditional block |
| form | input | 2 | Layout tag: 0 short, 1 wide, 2 classic, 3 undefined |
| instr | input | 32 | Instruction word (short form in bits [15:0]) |
| src_idx | output | 4 | Register-file read index |
| src_data | input | 32 | Register-file read data |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 4 | Register write index |
| rf_wdata | output | 32 | Register write data |
| pc_we | output | 1 | PC write enable |
| pc_wdata | output | 32 | PC write data |
| flags_we | output | 1 | Flag word was updated |
| flags_out | output | 4 | Next flags {N,Z,C,V} |
| undef | output | 1 | Undefined instruction detected |

## Verification
The bench targets the zero shift field. A design that treats it as a shift of 0 returns the operand unchanged and a stale carry, where the correct result is all sign bits with C equal to bit 31. The split wide-form shift field uses an amount whose halves differ. Swapped or misaligned pieces give a different shift count, which shows up as a different result. Wide-form register numbers 13 and 15 must not write, while 14 must; a wrong compare either drops the legal case or lets the illegal write through. The bench also covers a PC destination with bit 20 set, a short form inside a conditional block, a failing condition, and a set V input, so that a design which updates flags where it must not, or clears V, changes `flags_out`.

// File: rtl/asr_pkg.sv
package asr_pkg;
  parameter int unsigned XLEN   = 32;
  parameter int unsigned NREGS  = 16;
  localparam int unsigned IDX_W = $clog2(NREGS);
  localparam int unsigned SH_W  = $clog2(XLEN);
  localparam int unsigned PC_IDX = NREGS - 1;
  localparam int unsigned SP_IDX = NREGS - 3;

  typedef enum logic [1:0] {
    FORM_SHORT   = 2'd0,
    FORM_WIDE    = 2'd1,
    FORM_CLASSIC = 2'd2,
    FORM_NONE    = 2'd3
  } form_e;

  // Sign-filling right shift; field 0 stands for a shift of XLEN.
  // Returns {carry, result}.
  function automatic logic [XLEN:0] asr_shift(input logic [XLEN-1:0] x,
                                              input logic [SH_W-1:0] fld);
    logic [SH_W:0] amt;
    logic signed [XLEN:0] ext;
    logic signed [XLEN:0] sh;
    amt = (fld == '0) ? (SH_W+1)'(XLEN) : {1'b0, fld};
    ext = {x, 1'b0};
    sh  = ext >>> amt;
    return {sh[0], sh[XLEN:1]};
  endfunction
endpackage

// File: rtl/asr_field_decode.sv
module asr_field_decode
  import asr_pkg::*;
(
  input  logic [1:0]        form,
  input  logic [XLEN-1:0]   instr,
  input  logic              in_it_block,
  output logic [IDX_W-1:0]  rd,
  output logic [IDX_W-1:0]  rm,
  output logic [SH_W-1:0]   sh_fld,
  output logic              set_flags,
  output logic              illegal
);
  logic wide_bad;
  logic unused_bits;

  assign unused_bits = ^{instr[31:21], instr[19:16], instr[5:4]};

  always_comb begin
    rd = '0; rm = '0; sh_fld = '0; set_flags = 1'b0; illegal = 1'b0; wide_bad = 1'b0;
    unique case (form_e'(form))
      FORM_SHORT: begin
        rd        = {1'b0, instr[2:0]};
        rm        = {1'b0, instr[5:3]};
        sh_fld    = instr[10:6];
        set_flags = ~in_it_block;
      end
      FORM_WIDE: begin
        rd        = instr[11:8];
        rm        = instr[3:0];
        sh_fld    = {instr[14:12], instr[7:6]};
        set_flags = instr[20];
        wide_bad  = (rd == IDX_W'(SP_IDX)) || (rd == IDX_W'(PC_IDX)) ||
                    (rm == IDX_W'(SP_IDX)) || (rm == IDX_W'(PC_IDX));
        illegal   = wide_bad;
      end
      FORM_CLASSIC: begin
        rd        = instr[15:12];
        rm        = instr[3:0];
        sh_fld    = instr[11:7];
        set_flags = instr[20];
      end
      default: illegal = 1'b1;
    endcase
  end

  // R4: the wide form never passes a forbidden index as legal
  always_comb begin
    if (form == FORM_WIDE && !illegal)
      a_r4_wide_regs_legal: assert (rd != IDX_W'(PC_IDX) && rm != IDX_W'(SP_IDX));
  end
endmodule

// File: rtl/asr_shifter.sv
module asr_shifter
  import asr_pkg::*;
(
  input  logic [XLEN-1:0] opnd,
  input  logic [SH_W-1:0] sh_fld,
  output logic [XLEN-1:0] result,
  output logic            carry
);
  logic [XLEN:0] packed_out;

  assign packed_out = asr_shift(opnd, sh_fld);
  assign result     = packed_out[XLEN-1:0];
  assign carry      = packed_out[XLEN];

  // R6: the sign bit always survives the shift
  always_comb begin
    a_r6_sign_kept: assert (result[XLEN-1] == opnd[XLEN-1]);
  end
endmodule

// File: rtl/asr_flag_gen.sv
module asr_flag_gen
  import asr_pkg::*;
(
  input  logic [XLEN-1:0] result,
  input  logic            carry,
  input  logic [3:0]      flags_in,
  output logic [3:0]      flags_new
);
  // {N, Z, C, V}; V comes through untouched
  assign flags_new = {result[XLEN-1], (result == '0), carry, flags_in[0]};
endmodule

// File: rtl/asr_exec_unit.sv
module asr_exec_unit
  import asr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic              cond_pass,
  input  logic              in_it_block,
  input  logic [1:0]        form,
  input  logic [XLEN-1:0]   instr,
  output logic [IDX_W-1:0]  src_idx,
  input  logic [XLEN-1:0]   src_data,
  input  logic [3:0]        flags_in,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_waddr,
  output logic [XLEN-1:0]   rf_wdata,
  output logic              pc_we,
  output logic [XLEN-1:0]   pc_wdata,
  output logic              flags_we,
  output logic [3:0]        flags_out,
  output logic              undef
);
  logic [IDX_W-1:0] dec_rd;
  logic [SH_W-1:0]  dec_sh;
  logic             dec_setf;
  logic             dec_illegal;
  logic [XLEN-1:0]  sh_result;
  logic             sh_carry;
  logic [3:0]       flags_new;

  // named events for the checks
  logic go;
  logic to_pc;
  logic to_rf;
  logic upd_flags;

  asr_field_decode u_dec (
    .form(form), .instr(instr), .in_it_block(in_it_block),
    .rd(dec_rd), .rm(src_idx), .sh_fld(dec_sh),
    .set_flags(dec_setf), .illegal(dec_illegal)
  );

  asr_shifter u_shf (
    .opnd(src_data), .sh_fld(dec_sh), .result(sh_result), .carry(sh_carry)
  );

  asr_flag_gen u_flg (
    .result(sh_result), .carry(sh_carry), .flags_in(flags_in), .flags_new(flags_new)
  );

  assign go        = issue & cond_pass & ~dec_illegal;
  assign to_pc     = go & (dec_rd == IDX_W'(PC_IDX));
  assign to_rf     = go & ~to_pc;
  assign upd_flags = to_rf & dec_setf;

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we     <= 1'b0;
      rf_waddr  <= '0;
      rf_wdata  <= '0;
      pc_we     <= 1'b0;
      pc_wdata  <= '0;
      flags_we  <= 1'b0;
      flags_out <= '0;
      undef     <= 1'b0;
    end else begin
      rf_we     <= to_rf;
      rf_waddr  <= dec_rd;
      rf_wdata  <= sh_result;
      pc_we     <= to_pc;
      pc_wdata  <= sh_result;
      flags_we  <= upd_flags;
      flags_out <= upd_flags ? flags_new : flags_in;
      undef     <= issue & cond_pass & dec_illegal;
    end
  end

  // R8: a PC write never comes with a flag or register write
  a_r8_pc_no_flags: assert property (@(posedge clk) disable iff (rst)
    pc_we |-> (!flags_we && !rf_we));

  // R4 / R11: an undefined instruction writes nothing
  a_r4_undef_silent: assert property (@(posedge clk) disable iff (rst)
    undef |-> (!rf_we && !pc_we && !flags_we));

  // R9: a failed condition leaves every write port idle
  a_r9_fail_idle: assert property (@(posedge clk) disable iff (rst)
    (!cond_pass && !rst) |=> (!rf_we && !pc_we && !flags_we && !undef));

  // R7: V is carried over from the input in every case
  a_r7_v_kept: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (flags_out[0] == $past(flags_in[0])));

  // R7: N and Z agree with the data written
  a_r7_nz_match: assert property (@(posedge clk) disable iff (rst)
    flags_we |-> (flags_out[3] == rf_wdata[XLEN-1] && flags_out[2] == (rf_wdata == '0)));

  // R10: at most one write target per cycle
  a_r10_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rf_we, pc_we, undef}));
endmodule

// File: tb/asr_exec_unit_test.sv
module asr_exec_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        issue, cond_pass, in_it_block;
  logic [1:0]  form;
  logic [31:0] instr;
  logic [3:0]  src_idx;
  logic [31:0] src_data;
  logic [3:0]  flags_in;
  logic        rf_we, pc_we, flags_we, undef;
  logic [3:0]  rf_waddr, flags_out;
  logic [31:0] rf_wdata, pc_wdata;

  int total = 0;
  int bad   = 0;
  logic [31:0] rf [16];

  always #2.5 clk = ~clk;

  asr_exec_unit uut (
    .clk(clk), .rst(rst), .issue(issue), .cond_pass(cond_pass),
    .in_it_block(in_it_block), .form(form), .instr(instr),
    .src_idx(src_idx), .src_data(src_data), .flags_in(flags_in),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .pc_we(pc_we), .pc_wdata(pc_wdata), .flags_we(flags_we),
    .flags_out(flags_out), .undef(undef)
  );

  always_comb src_data = rf[src_idx];

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // vector: form(2) it(1) cond(1) s(1) rd(4) rm(4) imm(5) flags(4) = 22 bits
  localparam int NV = 14;
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b1, 1'b0, 4'd2,  4'd1,  5'd4,  4'b0000}, // R1 R2 short, flags on
    {2'd0, 1'b1, 1'b1, 1'b0, 4'd3,  4'd5,  5'd0,  4'b1010}, // R2 R6 in block, shift 32
    {2'd1, 1'b0, 1'b1, 1'b1, 4'd9,  4'd6,  5'd23, 4'b0001}, // R3 split field
    {2'd1, 1'b0, 1'b1, 1'b0, 4'd4,  4'd7,  5'd1,  4'b0110}, // R3 no flags
    {2'd1, 1'b0, 1'b1, 1'b1, 4'd13, 4'd2,  5'd3,  4'b0000}, // R4 rd 13
    {2'd1, 1'b0, 1'b1, 1'b1, 4'd1,  4'd15, 5'd3,  4'b0000}, // R4 rm 15
    {2'd2, 1'b0, 1'b1, 1'b1, 4'd10, 4'd4,  5'd7,  4'b1001}, // R5 R7 zero result, V kept
    {2'd2, 1'b0, 1'b1, 1'b1, 4'd15, 4'd3,  5'd2,  4'b0100}, // R8 PC dest
    {2'd2, 1'b0, 1'b1, 1'b1, 4'd0,  4'd0,  5'd0,  4'b0000}, // R6 shift 32 carry
    {2'd2, 1'b0, 1'b0, 1'b1, 4'd5,  4'd8,  5'd31, 4'b0011}, // R9 cond fail
    {2'd3, 1'b0, 1'b1, 1'b1, 4'd5,  4'd8,  5'd2,  4'b0000}, // R11 bad form
    {2'd2, 1'b0, 1'b1, 1'b0, 4'd6,  4'd9,  5'd16, 4'b1111}, // R5 no flags
    {2'd1, 1'b0, 1'b1, 1'b1, 4'd14, 4'd12, 5'd0,  4'b0000}, // R4 reg 14 legal
    {2'd0, 1'b0, 1'b1, 1'b0, 4'd7,  4'd6,  5'd31, 4'b0001}  // R6 shift 31
  };

  function automatic logic [31:0] build(input logic [1:0] f, input logic s,
                                        input logic [3:0] d, input logic [3:0] m,
                                        input logic [4:0] k);
    case (f)
      2'd0:    return {16'h0, 5'b00010, k, m[2:0], d[2:0]};
      2'd1:    return {11'b11101010010, s, 4'hF, 1'b0, k[4:2], d, k[1:0], 2'b10, m};
      default: return {4'hE, 7'b0001101, s, 4'h0, d, k, 3'b100, m};
    endcase
  endfunction

  task automatic run_vec(input logic [21:0] v);
    logic [1:0] f; logic it, c, s; logic [3:0] d, m, fi; logic [4:0] k;
    logic ill, setf, fire, to_pc; logic [31:0] r, x; logic cy; int amt;
    logic [3:0] exp_fl;
    {f, it, c, s, d, m, k, fi} = v;
    @(negedge clk);
    issue = 1'b1; cond_pass = c; in_it_block = it; form = f;
    instr = build(f, s, d, m, k); flags_in = fi;
    #1;
    if (f != 2'd3) check("R1", "src_idx", {28'h0, src_idx}, {28'h0, (f == 2'd0) ? {1'b0, m[2:0]} : m});
    // bench model: shift one bit at a time
    x = rf[m]; amt = (k == 0) ? 32 : int'(k); r = x; cy = 1'b0;
    for (int i = 0; i < amt; i++) begin cy = r[0]; r = {r[31], r[31:1]}; end
    ill   = (f == 2'd3) || (f == 2'd1 && (d == 13 || d == 15 || m == 13 || m == 15));
    setf  = (f == 2'd0) ? !it : s;
    fire  = c && !ill;
    to_pc = fire && f == 2'd2 && d == 15;
    exp_fl = (fire && !to_pc && setf) ? {r[31], r == 0, cy, fi[0]} : fi;
    @(negedge clk);
    check("R10", "rf_we",    {31'h0, rf_we},    {31'h0, fire && !to_pc});
    check("R8",  "pc_we",    {31'h0, pc_we},    {31'h0, to_pc});
    check("R7",  "flags_we", {31'h0, flags_we}, {31'h0, fire && !to_pc && setf});
    check("R7",  "flags_out", {28'h0, flags_out}, {28'h0, exp_fl});
    check("R4",  "undef",    {31'h0, undef},    {31'h0, c && ill});
    if (fire && !to_pc) begin
      check("R6", "rf_wdata", rf_wdata, r);
      check("R2", "rf_waddr", {28'h0, rf_waddr}, {28'h0, d});
    end
    if (to_pc) check("R8", "pc_wdata", pc_wdata, r);
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 32'h9E37_79B9 * (i + 1);
    rf[0] = 32'h8000_0001; rf[1] = 32'h7FFF_FFFF; rf[4] = 32'h0000_0000;
    rf[5] = 32'hFFFF_FFFF; rf[6] = 32'hC0FF_EE5A;
    rst = 1'b1; issue = 1'b0; cond_pass = 1'b0; in_it_block = 1'b0;
    form = 2'd0; instr = '0; flags_in = 4'hF;
    repeat (3) @(negedge clk);
    check("R10", "reset enables", {28'h0, rf_we, pc_we, flags_we, undef}, 32'h0);
    check("R10", "reset flags", {28'h0, flags_out}, 32'h0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);
    // R9: not issued, legal classic instruction
    @(negedge clk);
    issue = 1'b0; cond_pass = 1'b1; form = 2'd2; instr = build(2'd2, 1'b1, 4'd3, 4'd1, 5'd1);
    flags_in = 4'b0101;
    @(negedge clk);
    check("R9", "idle enables", {28'h0, rf_we, pc_we, flags_we, undef}, 32'h0);
    check("R9", "idle flags", {28'h0, flags_out}, 32'h5);
    // R10: synchronous reset clears a pending write
    issue = 1'b1;
    @(negedge clk);
    check("R10", "write before reset", {31'h0, rf_we}, 32'h1);
    rst = 1'b1;
    @(negedge clk);
    check("R10", "reset clears", {28'h0, rf_we, pc_we, flags_we, undef}, 32'h0);
    rst = 1'b0; issue = 1'b0;
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule